// File: doc/BRIEF.md
# Digital Potentiometer Serial Slave

This block is the two-wire serial slave in front of a single-channel digital potentiometer. It runs on a fast system clock and oversamples the bus clock and data lines. It finds START and STOP conditions and decodes write frames of three bytes: a device identifier, a register index and a data byte. It also handles the combined read, in which a repeated START separates the index byte from a second identifier that has the read bit set. The block answers with an open-drain pull-down enable, which it uses both for acknowledges and for read data.

Index 0 reaches one of two 7-bit words. One is the live wiper code. The other is the shadow copy of the power-up value held in nonvolatile storage. Bit 7 of a mode register at index 2 picks which word index 0 reaches. When that bit is clear, a write at index 0 changes both words, and the STOP that closes the frame raises a store request to an external nonvolatile controller. That controller reports when it is busy, and it loads the recalled value at power-up. The wiper code is a plain output that goes to the switch array.

The bus interface itself has no flow control. The master sets the pace of every byte, and the slave's only way to refuse a byte is to withhold its acknowledge.

Top module: `dpot_i2c_slave`

## Requirements
- R1: An identifier byte whose top five bits are 01010, whose bits 2:1 equal `dev_sel_i`, and whose bit 0 is the R/W flag (1 = read) is acknowledged. Any other identifier gets no acknowledge, and the slave waits for the next START.
- R2: Bytes move MSB first. Incoming bits are sampled on SCL rising edges, and the slave changes its pull-down only while SCL is low.
- R3: The slave pulls SDA low during the ninth clock after a matching identifier, after every index byte and after every write data byte.
- R4: A data byte written to index 0 reaches `wiper_o` at the SCL falling edge that ends its eighth bit. Bit 7 of the byte is discarded.
- R5: The mode register resets to 0 and stores only bit 7 of a byte written to index 2. Reading index 2 returns that bit in position 7 and zeros in bits 6:0.
- R6: With the mode bit clear, a write to index 0 sets both the wiper and the shadow value, and a read of index 0 returns the shadow value. With the mode bit set, a write changes only the wiper, and a read returns the wiper. Read values are zero-extended to 8 bits.
- R7: `store_req_o` pulses for one cycle after the STOP that closes a write to index 0 made with the mode bit clear. `store_val_o` then carries the written value. No other STOP raises the pulse.
- R8: While `nv_busy_i` is high, all bus activity, START included, is ignored and SDA is released.
- R9: A START or STOP that arrives in the middle of a byte ends the frame, and no register changes.
- R10: Indexes other than 0 and 2 are acknowledged, ignore writes and read back 00h.
- R11: In a read, the slave sends the selected byte again after each master acknowledge, and it releases the bus after a master non-acknowledge.
- R12: After reset, the wiper and the shadow value are both 40h. A pulse on `nv_load_i` loads `nv_load_val_i` into both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| dev_sel_i | input | 2 | Strap value that must match identifier bits 2:1 |
| nv_busy_i | input | 1 | Power-up or nonvolatile write in progress |
| nv_load_i | input | 1 | Load the recalled value into wiper and shadow |
| nv_load_val_i | input | 7 | Recalled value |
| sda_oe_o | output | 1 | Pull SDA low when high |
| wiper_o | output | 7 | Wiper tap code |
| store_req_o | output | 1 | One-cycle request to store the shadow value |
| store_val_o | output | 7 | Value to store |

## Verification
The assertions assume that SCL and SDA are already free of glitches. They also assume that each bus level lasts many system clocks, so that every edge is seen once after the input synchronizer. The assertions further assume that `nv_busy_i` never rises while the slave is pulling the line low. The bench keeps to these assumptions. It holds every bus phase for ten system clocks and changes SDA only while SCL is low, except for START and STOP. It raises the busy flag and the recall pulse only while the bus is idle.

// File: rtl/dpot_i2c_pkg.sv
package dpot_i2c_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_ID, PH_IDX, PH_DATA
  } phase_e;

  localparam logic [4:0] DEV_PREFIX = 5'b01010;
  localparam int         BYTE_W     = 8;
  localparam logic [7:0] IDX_WIPER  = 8'h00;
  localparam logic [7:0] IDX_MODE   = 8'h02;
endpackage

// File: rtl/dpot_bus_cond.sv
module dpot_bus_cond #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_smp,
  output logic start_det,
  output logic stop_det
);
  timeunit 1ns; timeprecision 1ps;

  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_p  <= scl_sh[SYNC-1];
      sda_p  <= sda_sh[SYNC-1];
    end
  end

  assign sda_smp   = sda_sh[SYNC-1];
  assign scl_rise  = scl_sh[SYNC-1] & ~scl_p;
  assign scl_fall  = ~scl_sh[SYNC-1] & scl_p;
  assign start_det = scl_sh[SYNC-1] & scl_p & sda_p & ~sda_sh[SYNC-1];
  assign stop_det  = scl_sh[SYNC-1] & scl_p & ~sda_p & sda_sh[SYNC-1];
endmodule

// File: rtl/dpot_reg_bank.sv
module dpot_reg_bank
  import dpot_i2c_pkg::*;
#(
  parameter int         W   = 7,
  parameter logic [W-1:0] RST = 7'h40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [7:0]   wr_idx,
  input  logic [7:0]   wr_data,
  input  logic [7:0]   rd_idx,
  output logic [7:0]   rd_data,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] wiper,
  output logic [W-1:0] shadow,
  output logic         mode_live
);
  timeunit 1ns; timeprecision 1ps;

  localparam int PAD = BYTE_W - W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper     <= RST;
      shadow    <= RST;
      mode_live <= 1'b0;
    end else if (load_en) begin
      wiper  <= load_val;
      shadow <= load_val;
    end else if (wr_en) begin
      if (wr_idx == IDX_WIPER) begin
        wiper <= wr_data[W-1:0];
        if (!mode_live) shadow <= wr_data[W-1:0];
      end else if (wr_idx == IDX_MODE) begin
        mode_live <= wr_data[BYTE_W-1];
      end
    end
  end

  always_comb begin
    if (rd_idx == IDX_WIPER)     rd_data = {{PAD{1'b0}}, mode_live ? wiper : shadow};
    else if (rd_idx == IDX_MODE) rd_data = {mode_live, {(BYTE_W-1){1'b0}}};
    else                         rd_data = '0;
  end

  AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !load_en) |=> $stable(wiper)); // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_live)); // R5
  AST_SHADOW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_live && !load_en) |=> $stable(shadow)); // R6
endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave
  import dpot_i2c_pkg::*;
#(
  parameter int           W    = 7,
  parameter int           SYNC = 2,
  parameter logic [W-1:0] RST  = 7'h40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_i,
  input  logic         sda_i,
  input  logic [1:0]   dev_sel_i,
  input  logic         nv_busy_i,
  input  logic         nv_load_i,
  input  logic [W-1:0] nv_load_val_i,
  output logic         sda_oe_o,
  output logic [W-1:0] wiper_o,
  output logic         store_req_o,
  output logic [W-1:0] store_val_o
);
  timeunit 1ns; timeprecision 1ps;

  logic scl_rise, scl_fall, sda_smp, start_det, stop_det;
  bus_st_e    state;
  phase_e     phase;
  logic [3:0] bitcnt;
  logic [7:0] shreg, reg_idx, rd_data;
  logic       rw, pend, macked, mode_live, id_ok, byte_done, commit;

  dpot_bus_cond #(.SYNC(SYNC)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_smp(sda_smp),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign id_ok     = (shreg[7:3] == DEV_PREFIX) && (shreg[2:1] == dev_sel_i);
  assign byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign commit    = byte_done && (phase == PH_DATA) && !nv_busy_i && !start_det && !stop_det;

  dpot_reg_bank #(.W(W), .RST(RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_idx(reg_idx), .wr_data(shreg),
    .rd_idx(reg_idx), .rd_data(rd_data), .load_en(nv_load_i), .load_val(nv_load_val_i),
    .wiper(wiper_o), .shadow(store_val_o), .mode_live(mode_live)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; phase <= PH_ID; bitcnt <= '0; shreg <= '0;
      reg_idx <= '0; rw <= 1'b0; pend <= 1'b0; macked <= 1'b0; store_req_o <= 1'b0;
    end else begin
      store_req_o <= 1'b0;
      if (nv_busy_i) begin
        state <= ST_IDLE;
        pend  <= 1'b0;
      end else if (start_det) begin
        state <= ST_RX; phase <= PH_ID; bitcnt <= '0; pend <= 1'b0;
      end else if (stop_det) begin
        store_req_o <= pend;
        pend  <= 1'b0;
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_smp};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              state <= ST_ACK;
              case (phase)
                PH_ID:   if (id_ok) rw <= shreg[0]; else state <= ST_IDLE;
                PH_IDX:  reg_idx <= shreg;
                default: if (reg_idx == IDX_WIPER && !mode_live) pend <= 1'b1;
              endcase
            end
          end
          ST_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              state <= ST_TX;
              shreg <= rd_data;
            end else begin
              state <= ST_RX;
              phase <= (phase == PH_ID) ? PH_IDX : PH_DATA;
            end
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              state <= ST_MACK; bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 4'd1;
              shreg  <= {shreg[6:0], 1'b0};
            end
          end
          ST_MACK: begin
            if (scl_rise) macked <= ~sda_smp;
            else if (scl_fall) begin
              if (macked) begin
                state <= ST_TX; shreg <= rd_data;
              end else state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o = (state == ST_ACK) || (state == ST_TX && !shreg[7]);

  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy_i |=> !sda_oe_o); // R8
  AST_STORE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    store_req_o |-> $past(stop_det)); // R7
  AST_BAD_ID_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_ID && !id_ok && !nv_busy_i && !start_det && !stop_det)
      |=> !sda_oe_o); // R1
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !nv_busy_i && $rose(sda_oe_o)) |-> $past(scl_fall)); // R2
endmodule

// File: tb/dpot_i2c_slave_test.sv
module dpot_i2c_slave_test;
  timeunit 1ns; timeprecision 1ps;

  localparam int Q = 10;
  localparam logic [6:0] ID_OK  = 7'b0101010;
  localparam logic [6:0] ID_BAD = 7'b0101001;

  // {index, data written, expected read, expected wiper, expected store}
  localparam logic [31:0] VEC [8] = '{
    {8'h02, 8'h80, 8'h80, 7'h40, 1'b0},
    {8'h00, 8'h15, 8'h15, 7'h15, 1'b0},
    {8'h00, 8'hFF, 8'h7F, 7'h7F, 1'b0},
    {8'h01, 8'h33, 8'h00, 7'h7F, 1'b0},
    {8'h02, 8'hFF, 8'h80, 7'h7F, 1'b0},
    {8'h02, 8'h00, 8'h00, 7'h7F, 1'b0},
    {8'h00, 8'h22, 8'h22, 7'h22, 1'b1},
    {8'h02, 8'h80, 8'h80, 7'h22, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic nv_busy = 1'b0, nv_load = 1'b0;
  logic [6:0] nv_val = '0;
  logic sda_oe, store_req;
  logic [6:0] wiper, store_val;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, stores = 0, viol = 0;
  logic [6:0] last_store = '0;
  logic scl_q = 1'b1, oe_q = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  dpot_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .dev_sel_i(2'b10),
    .nv_busy_i(nv_busy), .nv_load_i(nv_load), .nv_load_val_i(nv_val),
    .sda_oe_o(sda_oe), .wiper_o(wiper), .store_req_o(store_req), .store_val_o(store_val)
  );

  always @(posedge clk) begin
    if (store_req) begin stores <= stores + 1; last_store <= store_val; end
    if (scl && scl_q && sda_oe != oe_q) viol <= viol + 1;
    scl_q <= scl; oe_q <= sda_oe;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; w(Q); scl = 1; w(Q); sda_m = 0; w(Q); scl = 0; w(Q); endtask
  task automatic bstop();  sda_m = 0; w(Q); scl = 1; w(Q); sda_m = 1; w(Q); endtask
  task automatic bit_out(input logic b); sda_m = b; w(Q); scl = 1; w(Q); scl = 0; w(Q); endtask
  task automatic bit_in(output logic b);
    sda_m = 1; w(Q); scl = 1; w(Q/2); b = sda_line; w(Q/2); scl = 0; w(Q);
  endtask
  task automatic send_byte(input logic [7:0] d, inout int acks);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    if (!a) acks++;
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(~mack);
  endtask
  task automatic do_write(input logic [6:0] id, input logic [7:0] idx, input logic [7:0] d,
                          output int acks);
    acks = 0;
    bstart(); send_byte({id, 1'b0}, acks); send_byte(idx, acks); send_byte(d, acks); bstop();
  endtask
  task automatic do_read(input logic [7:0] idx, input int n, output logic [7:0] d0,
                         output logic [7:0] d1, output int acks);
    acks = 0; d1 = '0;
    bstart(); send_byte({ID_OK, 1'b0}, acks); send_byte(idx, acks);
    bstart(); send_byte({ID_OK, 1'b1}, acks);
    recv_byte(n > 1, d0);
    if (n > 1) recv_byte(1'b0, d1);
    bstop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int acks, s0;
    logic [7:0] d0, d1;
    w(4); rst_n = 1; w(4);
    chk(wiper == 7'h40, "R12 reset wiper", wiper, 'h40);
    chk(!sda_oe && !store_req, "R12 reset outputs", {sda_oe, store_req}, 0);
    do_read(8'h00, 1, d0, d1, acks);
    chk(d0 == 8'h40, "R6 R12 reset shadow read", d0, 'h40);
    chk(acks == 3, "R1 R3 read acks", acks, 3);

    foreach (VEC[k]) begin
      s0 = stores;
      do_write(ID_OK, VEC[k][31:24], VEC[k][23:16], acks);
      w(Q);
      chk(acks == 3, "R3 write acks", acks, 3);
      chk(wiper == VEC[k][7:1], "R4 R6 wiper after write", wiper, VEC[k][7:1]);
      chk((stores - s0) == int'(VEC[k][0]), "R7 store count", stores - s0, VEC[k][0]);
      do_read(VEC[k][31:24], 1, d0, d1, acks);
      chk(d0 == VEC[k][15:8], "R5 R6 R10 read back", d0, VEC[k][15:8]);
    end
    chk(last_store == 7'h22, "R7 stored value", last_store, 'h22);

    // R1: identifier with wrong strap bits
    do_write(ID_BAD, 8'h00, 8'h55, acks);
    chk(acks == 0, "R1 bad id no ack", acks, 0);
    chk(wiper == 7'h22, "R1 bad id no write", wiper, 'h22);

    // R9: STOP in the middle of a data byte
    s0 = stores; acks = 0;
    bstart(); send_byte({ID_OK, 1'b0}, acks); send_byte(8'h00, acks);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bstop(); w(Q);
    chk(wiper == 7'h22 && stores == s0, "R9 abort no commit", wiper, 'h22);

    // R8: busy ignores the bus
    nv_busy = 1; w(2);
    do_write(ID_OK, 8'h00, 8'h11, acks);
    chk(acks == 0, "R8 busy no ack", acks, 0);
    chk(wiper == 7'h22, "R8 busy no write", wiper, 'h22);
    nv_busy = 0; w(Q);

    // R11: two-byte read, master acks first byte
    do_read(8'h00, 2, d0, d1, acks);
    chk(d0 == 8'h22 && d1 == 8'h22, "R11 repeated read", {d0, d1}, 'h2222);

    // R7: live-mode write raises no store
    s0 = stores;
    do_write(ID_OK, 8'h00, 8'h30, acks); w(Q);
    chk(stores == s0 && wiper == 7'h30, "R7 live write no store", stores - s0, 0);

    // R12: recall load
    nv_val = 7'h5A; nv_load = 1; w(1); nv_load = 0; w(2);
    chk(wiper == 7'h5A, "R12 recall wiper", wiper, 'h5A);
    do_write(ID_OK, 8'h02, 8'h00, acks);
    do_read(8'h00, 1, d0, d1, acks);
    chk(d0 == 8'h5A, "R12 recall shadow", d0, 'h5A);

    chk(viol == 0, "R2 pull-down changed with SCL high", viol, 0);
    finish_run();
  end
endmodule